// File: doc/BRIEF.md
# HDLC Frame Receiver with Station Address Filter

This block takes a bit-serial synchronous line, one bit for each cycle in which `bit_en` is high, and recovers HDLC-style frames from it. It watches for the flag pattern at all times, including inside a frame. It removes the zero bits that the transmitter inserted after runs of ones. A long run of ones is treated as an abort and sends the block back to hunting. It builds characters of a selectable length and pushes each one through a single-cycle FIFO write strobe. Each recognised flag also drops a low-active sync output for one bit period.

An optional filter examines the first eight data bits of every frame, which form the address. With the filter off, every character of every frame is written. With the filter on, a frame is kept only if its address equals the station address or the broadcast value 0xFF. The comparison can be limited to the upper nibble. A rejected frame produces no writes and no end-of-frame pulse. Line bits take eight bit periods to reach the character datapath, so flag bits never reach the FIFO.

Top module: `hdlc_addr_rx`

## Requirements
- R1: When the last eight line bits, in arrival order, are 0,1,1,1,1,1,1,0 (flag 0x7E), `sync_n` is low from the clock after that bit's `bit_en` cycle until the next `bit_en` cycle, and is high at all other times.
- R2: A flag seen inside a frame closes it. `frame_end` pulses for one clock, in the clock after the flag's last bit, if the frame held at least one data bit and was passed. The same flag opens the next frame, and an empty frame between flags gives no pulse.
- R3: Inside a frame, a zero that arrives after exactly five consecutive ones is removed and is not part of the data.
- R4: Seven consecutive ones form an abort. The frame is dropped with no `frame_end`, characters not yet written are discarded, and the block hunts until the next flag.
- R5: `char_len` 0, 1, 2 and 3 select 5, 6, 7 and 8 bits per character. The first data bit received lands in bit 0, so the character is right-justified in `fifo_data`.
- R6: Bits of `fifo_data` above the character hold the raw line bits that follow the character's last bit, in arrival order from the lowest unused bit upward.
- R7: With `addr_filt_en` low, every complete character of every frame is written.
- R8: With `addr_filt_en` high, a frame passes only if its first eight data bits (first received in bit 0) equal `station_addr` or 0xFF. A failing frame writes nothing and gives no `frame_end`.
- R9: With `addr_hi_only` high, only bits 7..4 of the address are compared with the station address. 0xFF is still accepted.
- R10: The address is written as an ordinary character. With the filter on, a character completed before the eighth data bit is held and written in the clock after the `bit_en` cycle that brings the eighth data bit out of the line delay.
- R11: Data bits left over at the closing flag that do not fill a whole character are discarded.
- R12: After reset, `sync_n` is high, `fifo_wr` and `frame_end` are low and the block is hunting. `fifo_wr` is a one-clock pulse, and `fifo_data` changes only with it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Line bit strobe, one per receive bit period |
| rx_bit | input | 1 | Serial line data, sampled when bit_en is high |
| addr_filt_en | input | 1 | Enable the address filter |
| addr_hi_only | input | 1 | Compare only the upper four address bits |
| station_addr | input | 8 | Station address for the filter |
| char_len | input | 2 | Character length code (5 to 8 bits) |
| sync_n | output | 1 | Low for one bit period after a flag |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_data | output | 8 | Character written to the FIFO |
| frame_end | output | 1 | Closing flag of a passed frame |

## Verification
`sync_n` and `frame_end` are due in the clock after the `bit_en` cycle that carries the flag's last bit. A character write is due in the clock after the `bit_en` cycle that carries the eighth line bit following the character's last bit, or the address's last bit when the character is held. The bench drives one bit per strobe and samples every output at the falling edge right after that strobe's rising edge. Each observed event is tagged with the index of the line bit that produced it, and that index is compared with the one the bench computes from the bit stream it built. Two further falling-edge samples in every bit period confirm that each pulse lasts one clock and that `sync_n` holds its level.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

    localparam int               FLAG_LEN  = 8;
    localparam logic [7:0]       FLAG_PAT  = 8'h7E;
    localparam int               STUFF_RUN = 5;
    localparam int               ABORT_RUN = 7;

    typedef enum logic {
        LINK_HUNT,
        LINK_FRAME
    } link_state_e;

    typedef enum logic [1:0] {
        ADR_PEND,
        ADR_PASS,
        ADR_DROP
    } adr_state_e;

    // Per-strobe events from the line window
    typedef struct packed {
        logic flag;      // flag completed by this bit
        logic abort;     // abort run completed by this bit
        logic old_bit;   // bit leaving the window
        logic old_keep;  // leaving bit is real data (not stuffed, not flag)
    } line_ev_t;

    function automatic int char_bits(input logic [1:0] code);
        return 5 + int'(code);
    endfunction

endpackage

// File: rtl/hdlc_line_window.sv
module hdlc_line_window
    import hdlc_rx_pkg::*;
#(
    parameter int          WIN   = FLAG_LEN,
    parameter logic [WIN-1:0] PAT = FLAG_PAT,
    parameter int          STUFF = STUFF_RUN,
    parameter int          ABRT  = ABORT_RUN
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           bit_en,
    input  logic           rx_bit,
    output line_ev_t       ev,
    output logic [WIN-1:0] follow
);

    localparam int RUN_W = $clog2(ABRT + 1);

    logic [WIN-1:0]   win_q;
    logic [WIN-1:0]   keep_q;
    logic [WIN-1:0]   win_d;
    logic [RUN_W-1:0] run_q;
    logic             stuffed;

    always_comb begin
        win_d       = {win_q[WIN-2:0], rx_bit};
        stuffed     = !rx_bit && (run_q == RUN_W'(STUFF));
        ev.flag     = bit_en && (win_d == PAT);
        ev.abort    = bit_en && rx_bit && (run_q == RUN_W'(ABRT - 1));
        ev.old_bit  = win_q[WIN-1];
        ev.old_keep = keep_q[WIN-1];
        follow      = win_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            win_q  <= '0;
            keep_q <= '0;
            run_q  <= '0;
        end else if (bit_en) begin
            win_q <= win_d;
            if (ev.flag || ev.abort) begin
                keep_q <= '0;
            end else begin
                keep_q <= {keep_q[WIN-2:0], !stuffed};
            end
            if (!rx_bit) begin
                run_q <= '0;
            end else if (run_q != RUN_W'(ABRT)) begin
                run_q <= run_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/hdlc_char_builder.sv
module hdlc_char_builder
    import hdlc_rx_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          restart,
    input  logic          shift_en,
    input  logic          din,
    input  logic [1:0]    len_code,
    input  logic [CW-1:0] follow,
    output logic          done,
    output logic [CW-1:0] char_out
);

    localparam int CNT_W = $clog2(CW);

    logic [CW-1:0]    sr_q;
    logic [CW-1:0]    sr_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last_idx;
    int               nbits;

    always_comb begin
        nbits    = char_bits(len_code);
        last_idx = CNT_W'(nbits - 1);
        sr_d     = {din, sr_q[CW-1:1]};
        done     = shift_en && (cnt_q == last_idx);
        for (int i = 0; i < CW; i++) begin
            if (i < nbits) begin
                char_out[i] = sr_d[CW - nbits + i];
            end else begin
                char_out[i] = follow[CW - 1 - (i - nbits)];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q  <= '0;
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else if (shift_en) begin
            sr_q  <= sr_d;
            cnt_q <= done ? '0 : cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/hdlc_addr_gate.sv
module hdlc_addr_gate
    import hdlc_rx_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          restart,
    input  logic          shift_en,
    input  logic          din,
    input  logic          filt_en,
    input  logic          hi_only,
    input  logic [CW-1:0] station,
    input  logic          char_done,
    input  logic [CW-1:0] char_byte,
    output logic          wr,
    output logic [CW-1:0] wr_data,
    output logic          passed
);

    localparam int CNT_W = $clog2(CW + 1);
    localparam int HALF  = CW / 2;

    logic [CNT_W-1:0] dcnt_q;
    logic [CW-1:0]    asr_q;
    logic [CW-1:0]    asr_d;
    adr_state_e       st_q;
    adr_state_e       st_eff;
    logic             hold_v;
    logic [CW-1:0]    hold_q;
    logic             decide;
    logic             hit;
    logic             park;

    always_comb begin
        asr_d   = {din, asr_q[CW-1:1]};
        decide  = shift_en && (dcnt_q == CNT_W'(CW - 1));
        hit     = (asr_d == {CW{1'b1}}) ||
                  (hi_only ? (asr_d[CW-1:HALF] == station[CW-1:HALF]) : (asr_d == station));
        st_eff  = decide ? (hit ? ADR_PASS : ADR_DROP) : st_q;
        passed  = !filt_en || (st_eff == ADR_PASS);
        wr      = 1'b0;
        wr_data = char_byte;
        park    = 1'b0;
        if (!filt_en) begin
            wr = char_done;
        end else if (char_done && st_eff == ADR_PASS) begin
            wr = 1'b1;
        end else if (char_done && st_eff == ADR_PEND) begin
            park = 1'b1;
        end else if (decide && hit && hold_v) begin
            wr      = 1'b1;
            wr_data = hold_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dcnt_q <= '0;
            asr_q  <= '0;
            st_q   <= ADR_PEND;
            hold_v <= 1'b0;
            hold_q <= '0;
        end else if (restart) begin
            dcnt_q <= '0;
            st_q   <= ADR_PEND;
            hold_v <= 1'b0;
        end else begin
            if (shift_en && dcnt_q != CNT_W'(CW)) begin
                dcnt_q <= dcnt_q + 1'b1;
                asr_q  <= asr_d;
            end
            st_q <= st_eff;
            if (park) begin
                hold_v <= 1'b1;
                hold_q <= char_byte;
            end else if (decide) begin
                hold_v <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/hdlc_addr_rx.sv
module hdlc_addr_rx
    import hdlc_rx_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bit_en,
    input  logic          rx_bit,
    input  logic          addr_filt_en,
    input  logic          addr_hi_only,
    input  logic [CW-1:0] station_addr,
    input  logic [1:0]    char_len,
    output logic          sync_n,
    output logic          fifo_wr,
    output logic [CW-1:0] fifo_data,
    output logic          frame_end
);

    line_ev_t      ev;
    logic [CW-1:0] follow;
    link_state_e   state_q;
    logic          had_data_q;
    logic          shift_en;
    logic          restart;
    logic          close;
    logic          c_done;
    logic [CW-1:0] c_byte;
    logic          g_wr;
    logic [CW-1:0] g_data;
    logic          g_pass;

    hdlc_line_window #(.WIN(CW)) win_i (
        .clk    (clk),
        .rst    (rst),
        .bit_en (bit_en),
        .rx_bit (rx_bit),
        .ev     (ev),
        .follow (follow)
    );

    always_comb begin
        shift_en = bit_en && ev.old_keep && (state_q == LINK_FRAME);
        restart  = ev.flag || ev.abort;
        close    = ev.flag && (state_q == LINK_FRAME) && (had_data_q || shift_en) && g_pass;
    end

    hdlc_char_builder #(.CW(CW)) chr_i (
        .clk      (clk),
        .rst      (rst),
        .restart  (restart),
        .shift_en (shift_en),
        .din      (ev.old_bit),
        .len_code (char_len),
        .follow   (follow),
        .done     (c_done),
        .char_out (c_byte)
    );

    hdlc_addr_gate #(.CW(CW)) adr_i (
        .clk       (clk),
        .rst       (rst),
        .restart   (restart),
        .shift_en  (shift_en),
        .din       (ev.old_bit),
        .filt_en   (addr_filt_en),
        .hi_only   (addr_hi_only),
        .station   (station_addr),
        .char_done (c_done),
        .char_byte (c_byte),
        .wr        (g_wr),
        .wr_data   (g_data),
        .passed    (g_pass)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= LINK_HUNT;
            had_data_q <= 1'b0;
            sync_n     <= 1'b1;
            fifo_wr    <= 1'b0;
            fifo_data  <= '0;
            frame_end  <= 1'b0;
        end else begin
            fifo_wr   <= g_wr;
            frame_end <= close;
            if (g_wr) begin
                fifo_data <= g_data;
            end
            if (bit_en) begin
                sync_n <= !ev.flag;
            end
            if (ev.abort) begin
                state_q <= LINK_HUNT;
            end else if (ev.flag) begin
                state_q <= LINK_FRAME;
            end
            if (restart) begin
                had_data_q <= 1'b0;
            end else if (shift_en) begin
                had_data_q <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/hdlc_addr_rx_chk.sv
module hdlc_addr_rx_chk #(
    parameter int CW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          bit_en,
    input logic          sync_n,
    input logic          fifo_wr,
    input logic [CW-1:0] fifo_data,
    input logic          frame_end
);

    // R1
    sync_release_chk: assert property (@(posedge clk) disable iff (rst)
        (!sync_n && bit_en) |=> sync_n);

    // R1
    sync_on_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(sync_n) |-> $past(bit_en));

    // R2
    end_with_flag_chk: assert property (@(posedge clk) disable iff (rst)
        frame_end |-> !sync_n);

    // R12
    wr_single_chk: assert property (@(posedge clk) disable iff (rst)
        fifo_wr |=> !fifo_wr);

    // R12
    data_steady_chk: assert property (@(posedge clk) disable iff (rst)
        !fifo_wr |-> $stable(fifo_data));

    // R7
    wr_after_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        fifo_wr |-> $past(bit_en));

endmodule

bind hdlc_addr_rx hdlc_addr_rx_chk #(.CW(CW)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .bit_en    (bit_en),
    .sync_n    (sync_n),
    .fifo_wr   (fifo_wr),
    .fifo_data (fifo_data),
    .frame_end (frame_end)
);

// File: tb/hdlc_addr_rx_tb_top.sv
`timescale 1ns/1ps
module hdlc_addr_rx_tb_top;

    localparam logic [7:0] FLAG_B = 8'h7E;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_en = 1'b0;
    logic       rx_bit = 1'b1;
    logic       filt = 1'b0;
    logic       hi_only = 1'b0;
    logic [7:0] station = 8'h00;
    logic [1:0] clen = 2'd3;
    logic       sync_n;
    logic       fifo_wr;
    logic [7:0] fifo_data;
    logic       frame_end;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int tot_wr = 0;
    bit done = 1'b0;

    bit         raw [0:1023];
    int         nr;
    bit         dbits [0:255];
    int         nd;
    int         dpos [0:255];
    int         ew_idx [0:127];
    logic [7:0] ew_dat [0:127];
    int         new_n;
    int         ew_ptr;
    int         efe [0:15];
    int         nfe;
    int         fe_ptr;
    logic [7:0] hist = 8'h00;
    string      req = "R7";
    string      fe_req = "R2";

    always #2.5 clk = ~clk;

    hdlc_addr_rx dut_i (
        .clk          (clk),
        .rst          (rst),
        .bit_en       (bit_en),
        .rx_bit       (rx_bit),
        .addr_filt_en (filt),
        .addr_hi_only (hi_only),
        .station_addr (station),
        .char_len     (clen),
        .sync_n       (sync_n),
        .fifo_wr      (fifo_wr),
        .fifo_data    (fifo_data),
        .frame_end    (frame_end)
    );

    task automatic chk(input bit ok, input string r, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", r, what, act, exp);
        end
    endtask

    task automatic clear_stream();
        nr = 0; nd = 0; new_n = 0; ew_ptr = 0; nfe = 0; fe_ptr = 0;
    endtask

    task automatic push(input bit b);
        raw[nr] = b;
        nr++;
    endtask

    task automatic push_flag();
        for (int i = 0; i < 8; i++) push(FLAG_B[i]);
    endtask

    task automatic put_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) dbits[nd + i] = v[i];
        nd += 8;
    endtask

    task automatic put_bit(input bit b);
        dbits[nd] = b;
        nd++;
    endtask

    // Appends one frame to raw[] and records the expected events
    task automatic add_frame(input bit lead, input bit abort_end, input int trail);
        int ones;
        int end_idx;
        int n;
        int rend;
        int widx;
        bit pass;
        logic [7:0] a;
        logic [7:0] b;
        if (lead) push_flag();
        ones = 0;
        for (int j = 0; j < nd; j++) begin
            push(dbits[j]);
            dpos[j] = nr - 1;
            ones = dbits[j] ? ones + 1 : 0;
            if (ones == 5) begin
                push(1'b0);   // R3 stuffed zero
                ones = 0;
            end
        end
        if (abort_end) begin
            for (int i = 0; i < 7; i++) push(1'b1);
        end else begin
            push_flag();
        end
        end_idx = nr - 1;
        n = 5 + int'(clen);
        a = 8'h00;
        if (nd >= 8) for (int i = 0; i < 8; i++) a[i] = dbits[i];
        pass = !filt || (nd >= 8 && (a == 8'hFF ||
               (hi_only ? (a[7:4] == station[7:4]) : (a == station))));
        for (int c = 0; (c + 1) * n <= nd; c++) begin
            rend = dpos[c * n + n - 1];
            b = 8'h00;
            for (int i = 0; i < n; i++) b[i] = dbits[c * n + i];
            for (int i = n; i < 8; i++) b[i] = raw[rend + 1 + i - n];
            widx = rend + 8;
            if (filt && nd >= 8 && widx < dpos[7] + 8) widx = dpos[7] + 8;
            if (pass && (!abort_end || widx <= end_idx)) begin
                ew_idx[new_n] = widx;
                ew_dat[new_n] = b;
                new_n++;
            end
        end
        if (!abort_end && nd > 0 && pass) begin
            efe[nfe] = end_idx;
            nfe++;
        end
        for (int i = 0; i < trail; i++) push(1'b1);
        nd = 0;
    endtask

    task automatic send_stream();
        bit exp_w;
        bit exp_f;
        for (int k = 0; k < nr; k++) begin
            @(negedge clk);
            rx_bit = raw[k];
            bit_en = 1'b1;
            @(negedge clk);
            bit_en = 1'b0;
            hist = {hist[6:0], raw[k]};
            chk(sync_n == (hist != FLAG_B), "R1", "sync_n after bit", int'(sync_n), int'(hist != FLAG_B));
            exp_w = (ew_ptr < new_n) && (ew_idx[ew_ptr] == k);
            if (fifo_wr || exp_w) begin
                chk(fifo_wr == exp_w, req, "write strobe at line bit", int'(fifo_wr), int'(exp_w));
                if (fifo_wr && exp_w)
                    chk(fifo_data == ew_dat[ew_ptr], req, "written character", int'(fifo_data), int'(ew_dat[ew_ptr]));
                if (exp_w) ew_ptr++;
            end
            if (fifo_wr) tot_wr++;
            exp_f = (fe_ptr < nfe) && (efe[fe_ptr] == k);
            if (frame_end || exp_f) begin
                chk(frame_end == exp_f, fe_req, "frame_end at line bit", int'(frame_end), int'(exp_f));
                if (exp_f) fe_ptr++;
            end
            @(negedge clk);
            chk(!fifo_wr && !frame_end, "R12", "pulse width", int'(fifo_wr) + int'(frame_end), 0);
            @(negedge clk);
            chk(sync_n == (hist != FLAG_B), "R1", "sync_n held", int'(sync_n), int'(hist != FLAG_B));
        end
        chk(ew_ptr == new_n, req, "writes consumed", ew_ptr, new_n);
        chk(fe_ptr == nfe, fe_req, "frame ends consumed", fe_ptr, nfe);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL R12 watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] adr;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        chk(sync_n == 1'b1, "R12", "sync_n after reset", int'(sync_n), 1);
        chk(fifo_wr == 1'b0, "R12", "fifo_wr after reset", int'(fifo_wr), 0);
        chk(frame_end == 1'b0, "R12", "frame_end after reset", int'(frame_end), 0);

        // Sweep: lengths R5 R6 R11, filter modes R7 R8 R9 R10, stuffing R3
        station = 8'hA5;
        for (int l = 0; l < 4; l++) begin
            for (int fm = 0; fm < 3; fm++) begin
                for (int ac = 0; ac < 4; ac++) begin
                    clen    = 2'(l);
                    filt    = (fm != 0);
                    hi_only = (fm == 2);
                    adr = (ac == 0) ? 8'hA5 : (ac == 1) ? 8'hFF : (ac == 2) ? 8'hA3 : 8'h35;
                    req = (fm == 0) ? "R7 R3 R5 R6 R11" : (ac == 2) ? "R9 R10" : "R8 R10";
                    fe_req = "R2";
                    clear_stream();
                    push(1'b1); push(1'b1);
                    put_byte(adr);
                    put_byte(8'hF8);
                    put_byte(8'h1F ^ 8'(l));
                    put_byte(8'h7E);
                    for (int t = 0; t <= l; t++) put_bit(t[0]);
                    add_frame(1'b1, 1'b0, 10);
                    send_stream();
                end
            end
        end

        // R4 abort inside a frame, then a fresh frame
        clen = 2'd3; filt = 1'b0; hi_only = 1'b0;
        req = "R4"; fe_req = "R4";
        clear_stream();
        put_byte(8'h5A);
        put_byte(8'h3C);
        add_frame(1'b1, 1'b1, 2);
        put_byte(8'hC3);
        add_frame(1'b1, 1'b0, 10);
        send_stream();

        // R2 shared closing/opening flag and an empty frame between flags
        req = "R2"; fe_req = "R2";
        clen = 2'd2;
        clear_stream();
        push_flag();
        put_byte(8'h12);
        put_byte(8'h9C);
        add_frame(1'b1, 1'b0, 0);
        put_byte(8'hE7);
        put_byte(8'h01);
        add_frame(1'b0, 1'b0, 10);
        send_stream();

        chk(tot_wr > 100, "R7", "total writes seen", tot_wr, 101);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule